// File: doc/BRIEF.md
# Programmable Pulse-Swallow Frequency Divider

This block divides a fast input clock by an integer ratio between 93 and 120 and emits one single-clock pulse per completed division period. Internally a dual-modulus prescaler divides by 8 or by 9. A coarse counter counts prescaler periods, and a swallow counter decides how many of those periods run at the longer modulus. The total period is eight times the coarse count plus the swallow count.

The ratio word is meant to come straight from a noise-shaping modulator that can present a new value every output period. The word is taken on the clock edge that ends a period, clamped to the legal range and split into its coarse and swallow parts. A carry out of the swallow field therefore raises the coarse count by one instead of saturating. Dedicated reload handling covers swallow counts of zero and one. With it, every ratio in the range works, including those where the swallow part is 0 or 1.

The modulus select is registered and can only change at a prescaler boundary. A synchronous reset clears the counters and the modulus select. The first period after reset is a complete programmed period.

Top module: `swallow_divider`

## Requirements
- R1: While `rst` is high, `div_pulse`, `pre_pulse` and `mod_sel` are low on every clock after the first. Counting the first rising edge with `rst` low as edge 1, the first `div_pulse` rises on edge R+1, where R is the clamped `ratio_in` sampled at edge 1.
- R2: The number of input clocks from one `div_pulse` to the next equals the clamped `ratio_in` sampled on the edge that raised the earlier pulse.
- R3: Each prescaler period, ended by one clock of `pre_pulse`, lasts 9 input clocks while `mod_sel` is 1 and 8 input clocks while `mod_sel` is 0.
- R4: `mod_sel` changes only on the clock edge that follows a clock in which `pre_pulse` is high.
- R5: A ratio whose swallow part (bits 2:0) is 0 keeps `mod_sel` at 0 for every prescaler period of that output period.
- R6: A ratio whose swallow part is 1 sets `mod_sel` to 1 for the first prescaler period only and to 0 for all the others.
- R7: An output period contains exactly P = ratio[6:3] prescaler periods, and the first S = ratio[2:0] of them are at modulus 9, followed by all the periods at modulus 8.
- R8: Every ratio from 93 to 120 inclusive is honoured exactly. This includes the steps where the swallow field wraps and the coarse count rises, such as 103 to 104 and 111 to 112.
- R9: A `ratio_in` below 93 acts as 93, and a `ratio_in` above 120 acts as 120.
- R10: `div_pulse` is high for exactly one input clock per output period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock being divided |
| rst | input | 1 | Synchronous reset, active high |
| ratio_in | input | RATIO_W (7) | Requested division ratio, taken at the end of each output period |
| div_pulse | output | 1 | One-clock pulse at the end of each output period |
| pre_pulse | output | 1 | One-clock pulse at the end of each prescaler period |
| mod_sel | output | 1 | Prescaler modulus select: 1 divides by 9, 0 divides by 8 |

## Verification
Three things happen on the same clock edge: the last prescaler period of an output period ends, the ratio word is captured, and the new modulus is loaded for the first prescaler period of the next output period. A fault in how these coincide would show up only in the period lengths of the following cycle. The bench changes `ratio_in` on every output pulse. It walks through the whole range, through swallow values 0 and 1, through wraps of the swallow field, through out-of-range words and through a random sequence. For every output period it counts the input clocks, the prescaler periods and the modulus-9 periods and compares them with values computed from the ratio held at the previous pulse. A reset asserted in the middle of a period checks that a restart runs a full first period.

// File: rtl/swdiv_pkg.sv
package swdiv_pkg;

  // Prescaler modulus state
  typedef enum logic {
    MODE_BASE = 1'b0,   // divide by 2**PRE_LOG2
    MODE_PLUS = 1'b1    // divide by 2**PRE_LOG2 + 1
  } presc_mode_t;

  // Keep a requested ratio inside the legal window
  function automatic int unsigned clamp_ratio(input int unsigned raw,
                                              input int unsigned lo,
                                              input int unsigned hi);
    if (raw < lo) return lo;
    if (raw > hi) return hi;
    return raw;
  endfunction

  // Number of prescaler periods in one output period
  function automatic int unsigned coarse_count(input int unsigned ratio,
                                               input int unsigned lg);
    return ratio >> lg;
  endfunction

  // Number of prescaler periods that run at the longer modulus
  function automatic int unsigned fine_count(input int unsigned ratio,
                                             input int unsigned lg);
    return ratio & ((32'd1 << lg) - 32'd1);
  endfunction

  // Length in input clocks of one prescaler period
  function automatic int unsigned period_len(input logic plus,
                                             input int unsigned lg);
    return (32'd1 << lg) + (plus ? 32'd1 : 32'd0);
  endfunction

endpackage

// File: rtl/swdiv_ratio_latch.sv
module swdiv_ratio_latch
  import swdiv_pkg::*;
#(
  parameter int unsigned RATIO_W   = 7,
  parameter int unsigned PRE_LOG2  = 3,
  parameter int unsigned RATIO_MIN = 93,
  parameter int unsigned RATIO_MAX = 120,
  localparam int unsigned P_W      = RATIO_W - PRE_LOG2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [RATIO_W-1:0]  ratio_in,
  output logic [P_W-1:0]      p_next,
  output logic [PRE_LOG2-1:0] s_next,
  output logic [RATIO_W-1:0]  ratio_q
);

  logic [RATIO_W-1:0] clamped;

  always_comb begin
    clamped = RATIO_W'(clamp_ratio(32'(ratio_in), RATIO_MIN, RATIO_MAX));
    p_next  = P_W'(coarse_count(32'(clamped), PRE_LOG2));
    s_next  = PRE_LOG2'(fine_count(32'(clamped), PRE_LOG2));
  end

  always_ff @(posedge clk) begin
    if (rst)       ratio_q <= RATIO_W'(RATIO_MIN);
    else if (load) ratio_q <= clamped;
  end

  // R9: a captured ratio always lies inside the legal window
  p_clamp_range_r9: assert property (@(posedge clk) disable iff (rst)
    load |=> (ratio_q >= RATIO_W'(RATIO_MIN) && ratio_q <= RATIO_W'(RATIO_MAX)));

endmodule

// File: rtl/swdiv_prescaler.sv
module swdiv_prescaler
  import swdiv_pkg::*;
#(
  parameter int unsigned PRE_LOG2 = 3,
  localparam int unsigned CW      = PRE_LOG2 + 1
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic modulus,
  output logic pre_tick
);

  logic [CW-1:0] phase;
  logic [CW-1:0] last;

  always_comb begin
    last     = CW'(period_len(modulus, PRE_LOG2) - 32'd1);
    pre_tick = run && (phase == last);
  end

  always_ff @(posedge clk) begin
    if (rst)                  phase <= '0;
    else if (!run || pre_tick) phase <= '0;
    else                      phase <= phase + CW'(1);
  end

  // R4: the modulus input must hold still inside a prescaler period
  p_mod_boundary_r4: assert property (@(posedge clk) disable iff (rst)
    (run && !pre_tick) |=> $stable(modulus));

endmodule

// File: rtl/swdiv_swallow_ctr.sv
module swdiv_swallow_ctr
  import swdiv_pkg::*;
#(
  parameter int unsigned PRE_LOG2 = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic                pre_tick,
  input  logic [PRE_LOG2-1:0] s_next,
  output logic                modulus
);

  presc_mode_t         mode_q;
  logic [PRE_LOG2-1:0] s_left;
  logic                s_zero_next;
  logic                s_zero_left;

  assign s_zero_next = (s_next == '0);
  assign s_zero_left = (s_left == '0);
  assign modulus     = (mode_q == MODE_PLUS);

  // Reload path: the first period of a new output period is decided
  // directly from the new swallow value, so S = 0 and S = 1 both work.
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_BASE;
      s_left <= '0;
    end else if (load) begin
      mode_q <= s_zero_next ? MODE_BASE : MODE_PLUS;
      s_left <= s_zero_next ? '0 : s_next - PRE_LOG2'(1);
    end else if (pre_tick) begin
      mode_q <= s_zero_left ? MODE_BASE : MODE_PLUS;
      s_left <= s_zero_left ? '0 : s_left - PRE_LOG2'(1);
    end
  end

  // Checker state: modulus-plus periods seen in the running output period
  logic [PRE_LOG2:0]   plus_seen;
  logic [PRE_LOG2-1:0] s_taken;

  always_ff @(posedge clk) begin
    if (rst) begin
      plus_seen <= '0;
      s_taken   <= '0;
    end else if (load) begin
      plus_seen <= '0;
      s_taken   <= s_next;
    end else if (pre_tick && modulus) begin
      plus_seen <= plus_seen + (PRE_LOG2+1)'(1);
    end
  end

  // R5: swallow value 0 starts the period at the base modulus
  p_zero_swallow_r5: assert property (@(posedge clk) disable iff (rst)
    (load && s_zero_next) |=> !modulus);

  // R6: swallow value 1 starts the period at the longer modulus
  p_one_swallow_r6: assert property (@(posedge clk) disable iff (rst)
    (load && s_next == PRE_LOG2'(1)) |=> modulus);

  // R7: once back at the base modulus, no longer period follows
  p_order_r7: assert property (@(posedge clk) disable iff (rst)
    (!load && !modulus) |=> !modulus);

  // R7: the number of longer periods equals the captured swallow value
  p_swallow_count_r7: assert property (@(posedge clk) disable iff (rst)
    (load && pre_tick) |->
      (plus_seen + (modulus ? (PRE_LOG2+1)'(1) : '0)) == {1'b0, s_taken});

endmodule

// File: rtl/swdiv_program_ctr.sv
module swdiv_program_ctr #(
  parameter int unsigned P_W = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           pre_tick,
  input  logic [P_W-1:0] p_next,
  output logic           run,
  output logic           load,
  output logic           wrap,
  output logic           out_pulse
);

  logic           primed;
  logic [P_W-1:0] p_left;

  always_comb begin
    run  = primed;
    wrap = pre_tick && (p_left == '0);
    load = wrap || !primed;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      primed    <= 1'b0;
      p_left    <= '0;
      out_pulse <= 1'b0;
    end else begin
      primed    <= 1'b1;
      out_pulse <= wrap;
      if (load)          p_left <= p_next - P_W'(1);
      else if (pre_tick) p_left <= p_left - P_W'(1);
    end
  end

  // R10: the output pulse lasts one clock
  p_pulse_width_r10: assert property (@(posedge clk) disable iff (rst)
    out_pulse |=> !out_pulse);

endmodule

// File: rtl/swallow_divider.sv
module swallow_divider
  import swdiv_pkg::*;
#(
  parameter int unsigned RATIO_W   = 7,
  parameter int unsigned PRE_LOG2  = 3,
  parameter int unsigned RATIO_MIN = 93,
  parameter int unsigned RATIO_MAX = 120
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [RATIO_W-1:0] ratio_in,
  output logic               div_pulse,
  output logic               pre_pulse,
  output logic               mod_sel
);

  localparam int unsigned P_W = RATIO_W - PRE_LOG2;
  localparam int unsigned GW  = RATIO_W + 1;

  // Named internal events
  logic                run;
  logic                load;
  logic                wrap;
  logic                pre_tick;
  logic                modulus;
  logic [P_W-1:0]      p_next;
  logic [PRE_LOG2-1:0] s_next;
  logic [RATIO_W-1:0]  ratio_q;

  swdiv_ratio_latch #(
    .RATIO_W(RATIO_W), .PRE_LOG2(PRE_LOG2),
    .RATIO_MIN(RATIO_MIN), .RATIO_MAX(RATIO_MAX)
  ) u_latch (
    .clk(clk), .rst(rst), .load(load), .ratio_in(ratio_in),
    .p_next(p_next), .s_next(s_next), .ratio_q(ratio_q)
  );

  swdiv_prescaler #(.PRE_LOG2(PRE_LOG2)) u_presc (
    .clk(clk), .rst(rst), .run(run), .modulus(modulus), .pre_tick(pre_tick)
  );

  swdiv_swallow_ctr #(.PRE_LOG2(PRE_LOG2)) u_swallow (
    .clk(clk), .rst(rst), .load(load), .pre_tick(pre_tick),
    .s_next(s_next), .modulus(modulus)
  );

  swdiv_program_ctr #(.P_W(P_W)) u_prog (
    .clk(clk), .rst(rst), .pre_tick(pre_tick), .p_next(p_next),
    .run(run), .load(load), .wrap(wrap), .out_pulse(div_pulse)
  );

  assign pre_pulse = pre_tick;
  assign mod_sel   = modulus;

  // Checker: input clocks since the last capture of a ratio
  logic [GW-1:0] gap;

  always_ff @(posedge clk) begin
    if (rst)       gap <= '0;
    else if (load) gap <= '0;
    else           gap <= gap + GW'(1);
  end

  // R2: a period ends exactly after the captured number of clocks
  p_period_r2: assert property (@(posedge clk) disable iff (rst)
    wrap |-> (gap == {1'b0, ratio_q} - GW'(1)));

  // R2: a period never runs past the captured length
  p_no_overrun_r2: assert property (@(posedge clk) disable iff (rst)
    (run && !load) |-> (gap < {1'b0, ratio_q}));

  // R1: reset silences every output
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!div_pulse && !mod_sel));

endmodule

// File: tb/test_swallow_divider.sv
module test_swallow_divider;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] ratio_in = 7'd100;
  logic       div_pulse;
  logic       pre_pulse;
  logic       mod_sel;

  int total = 0;
  int bad   = 0;
  int held  = 100;
  int cyc   = 0;

  always #5 clk = ~clk;

  swallow_divider i_swallow_divider (
    .clk(clk), .rst(rst), .ratio_in(ratio_in),
    .div_pulse(div_pulse), .pre_pulse(pre_pulse), .mod_sel(mod_sel)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      total++;
      $display("FAIL R2 watchdog expired: act=%0d exp<=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic int legal(input int r);
    if (r < 93)  return 93;
    if (r > 120) return 120;
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  // Starts at a negedge where div_pulse was just seen; the ratio held on
  // ratio_in at that edge governs the period now being measured.
  task automatic run_period(input int cap, input int next_in);
    int  e     = legal(cap);
    int  gap   = 0;
    int  ticks = 0;
    int  plus  = 0;
    int  cl    = 1;
    bit  seen_base = 0;
    bit  order_ok  = 1;
    bit  len_ok    = 1;
    bit  mod_ok    = 1;
    bit  prev_tick = 0;
    logic prev_mod = mod_sel;
    string sreq;
    ratio_in = 7'(next_in);
    do begin
      @(negedge clk);
      gap++;
      cl++;
      if (gap == 1)
        check(div_pulse == 1'b0, "R10", "pulse width", int'(div_pulse), 0);
      if (mod_sel !== prev_mod && !prev_tick) mod_ok = 0;
      if (pre_pulse) begin
        if (cl != (mod_sel ? 9 : 8)) len_ok = 0;
        ticks++;
        if (mod_sel) begin
          plus++;
          if (seen_base) order_ok = 0;
        end else begin
          seen_base = 1;
        end
        cl = 0;
      end
      prev_tick = pre_pulse;
      prev_mod  = mod_sel;
    end while (!div_pulse && gap < 400);
    sreq = ((e % 8) == 0) ? "R5" : (((e % 8) == 1) ? "R6" : "R7");
    check(gap == e, (cap != e) ? "R9" : "R2/R8", "output period", gap, e);
    check(ticks == e / 8, "R7", "prescaler periods", ticks, e / 8);
    check(plus == e % 8, sreq, "modulus-9 periods", plus, e % 8);
    check(order_ok, "R7", "long periods first", int'(order_ok), 1);
    check(len_ok, "R3", "prescaler period length", int'(len_ok), 1);
    check(mod_ok, "R4", "modulus change off boundary", int'(mod_ok), 1);
  endtask

  task automatic step(input int next_in);
    run_period(held, next_in);
    held = next_in;
  endtask

  task automatic t_reset(input int start);
    int gap = 0;
    rst      = 1'b1;
    ratio_in = 7'(start);
    repeat (3) @(negedge clk);
    check(div_pulse == 1'b0, "R1", "div_pulse in reset", int'(div_pulse), 0);
    check(pre_pulse == 1'b0, "R1", "pre_pulse in reset", int'(pre_pulse), 0);
    check(mod_sel == 1'b0, "R1", "mod_sel in reset", int'(mod_sel), 0);
    rst = 1'b0;
    do begin
      @(negedge clk);
      gap++;
    end while (!div_pulse && gap < 400);
    check(gap == legal(start) + 1, "R1", "first pulse after reset", gap,
          legal(start) + 1);
    held = start;
  endtask

  task automatic t_sweep;
    for (int r = 93; r <= 120; r++) step(r);
    step(100);
  endtask

  task automatic t_swallow_edges;
    step(96);
    step(97);
    step(112);
    step(113);
    step(103);
    step(104);
    step(111);
    step(112);
    step(100);
  endtask

  task automatic t_clamp;
    step(0);
    step(92);
    step(121);
    step(127);
    step(93);
    step(100);
  endtask

  task automatic t_random;
    for (int k = 0; k < 40; k++) step(int'($urandom_range(85, 127)));
    step(100);
  endtask

  task automatic t_rereset;
    repeat (37) @(negedge clk);
    t_reset(117);
    step(94);
    step(100);
  endtask

  initial begin
    t_reset(100);
    t_sweep();
    t_swallow_edges();
    t_clamp();
    t_random();
    t_rereset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule